// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home side of one memory slice in a shared-memory machine whose nodes talk over a point-to-point network instead of a shared bus. Every line of the slice has a directory entry with two parts. The first is a state: unused, shared, exclusive-clean or exclusive-dirty. The second is a full bit vector with one bit per node, recording which nodes hold a copy. Because the vector has one bit for every node, the node count is fixed when the block is built. A small data array holds the home copy of each line.

Requests arrive on a valid/ready port. For each request, the block consults the directory and sends targeted messages out on a second valid/ready port. These messages are data replies, share notices to an owner, forwards to a dirty owner, and invalidates to recorded sharers. Nothing is broadcast.

Back-pressure rules:
- A request is taken on a cycle where `req_valid` and `req_ready` are both high.
- An outgoing message is consumed on a cycle where `resp_valid` and `resp_ready` are both high.
- While `resp_valid` is high and `resp_ready` is low, the outgoing message holds steady.
- While a write waits for invalidate acknowledgements, `req_ready` is low for every request except an acknowledgement.

Message type codes, on 3 bits: READ=0, WRITE=1, WRITEBACK=2, DATA_REPLY=3, SHARE=4, FORWARD=5, INVALIDATE=6, INV_ACK=7.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, every line is unused with an empty sharer vector, `resp_valid` is 0, and `req_ready` is 1.
- R2: A READ (code 0) to an unused line produces one DATA_REPLY (code 3) to the requester, carrying the stored data with `resp_excl`=1. The requester is recorded as exclusive-clean owner.
- R3: A READ to an exclusive-clean line first sends SHARE (code 4) to the owner. On the next message slot it sends DATA_REPLY to the requester with `resp_excl`=0. The line becomes shared, holding owner and requester.
- R4: A READ to a shared line sends DATA_REPLY with `resp_excl`=0 and adds the requester to the sharer vector.
- R5: A READ to an exclusive-dirty line sends only FORWARD (code 5) to the owner, with `resp_src` set to the requester. The directory entry is left unchanged.
- R6: A WRITE (code 1) sends INVALIDATE (code 6) to every recorded holder of the line other than the writer, and to no other node. The invalidates go out in ascending node order, one per consumed message slot.
- R7: The DATA_REPLY to the writer (`resp_excl`=1) appears only after an INV_ACK (code 7) has been taken from each targeted node. It appears in the second cycle after the last acknowledgement is taken. The line then becomes exclusive-dirty with the writer as its only holder.
- R8: While a write awaits acknowledgements, `req_ready` stays low for any request other than INV_ACK, and no message is sent.
- R9: A WRITEBACK (code 2) stores its data in the line and sends nothing. If it comes from the exclusive owner, the line returns to unused with an empty vector. From any other node, the directory entry is unchanged.
- R10: While `resp_valid` is high and `resp_ready` is low, every output message field holds its value.
- R11: A WRITE with no other holders gets its exclusive DATA_REPLY in the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Request taken this cycle if valid |
| req_type | input | 3 | Request message type code |
| req_src | input | clog2(NODES) | Sending node |
| req_addr | input | clog2(LINES) | Line index |
| req_data | input | DATA_W | Line data (WRITEBACK) |
| resp_valid | output | 1 | Outgoing message present |
| resp_ready | input | 1 | Network accepts outgoing message |
| resp_type | output | 3 | Outgoing message type code |
| resp_src | output | clog2(NODES) | Home id, or requester for FORWARD |
| resp_dst | output | clog2(NODES) | Destination node |
| resp_addr | output | clog2(LINES) | Line index |
| resp_data | output | DATA_W | Line data for DATA_REPLY, else 0 |
| resp_excl | output | 1 | DATA_REPLY grants exclusive permission |

## Verification
The first outgoing message for a request is due in the cycle right after the edge that takes the request. Any follow-on message (the reply after a share notice, or each further invalidate) is due one consumed slot later. The writer's reply comes in the second cycle after its last acknowledgement is taken, so the cycle between is checked to be silent.

Each scenario task drives inputs just after a falling edge and samples at the next falling edge. The first message is therefore compared in exactly the cycle it is due, and each later message one cycle on. Back-pressure is checked by holding `resp_ready` low for one cycle and by presenting a non-acknowledgement request during a pending write.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [2:0] {
    MSG_READ       = 3'd0,
    MSG_WRITE      = 3'd1,
    MSG_WRITEBACK  = 3'd2,
    MSG_DATA_REPLY = 3'd3,
    MSG_SHARE      = 3'd4,
    MSG_FORWARD    = 3'd5,
    MSG_INVALIDATE = 3'd6,
    MSG_INV_ACK    = 3'd7
  } msg_e;

  typedef enum logic [1:0] {
    LN_UNUSED     = 2'd0,
    LN_SHARED     = 2'd1,
    LN_EXCL_CLEAN = 2'd2,
    LN_EXCL_DIRTY = 2'd3
  } line_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OUT  = 2'd1,
    ST_INV  = 2'd2,
    ST_ACK  = 2'd3
  } ctl_e;
endpackage

// File: rtl/dir_lowbit.sv
module dir_lowbit #(
  parameter int W  = 4,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx
);
  // lowest set bit wins; scanning from the top lets the lowest overwrite last
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  localparam int AW    = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     line_sel,
  output line_e             rd_state,
  output logic [NODES-1:0]  rd_vec,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dir_we,
  input  line_e             dir_wstate,
  input  logic [NODES-1:0]  dir_wvec,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_wdata
);
  line_e             st_q  [LINES];
  logic [NODES-1:0]  vec_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  assign rd_state = st_q[line_sel];
  assign rd_vec   = vec_q[line_sel];
  assign rd_data  = dat_q[line_sel];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]  <= LN_UNUSED;
        vec_q[g] <= '0;
        dat_q[g] <= '0;
      end else if (line_sel == AW'(g)) begin
        if (dir_we) begin
          st_q[g]  <= dir_wstate;
          vec_q[g] <= dir_wvec;
        end
        if (dat_we) dat_q[g] <= dat_wdata;
      end
    end
  end

  // R1
  unused_line_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_state == LN_UNUSED) |-> (rd_vec == '0));

  // R7
  excl_single_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_state == LN_EXCL_CLEAN || rd_state == LN_EXCL_DIRTY) |-> ($countones(rd_vec) == 1));
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES   = 4,
  parameter int LINES   = 16,
  parameter int DATA_W  = 32,
  parameter int HOME_ID = 0,
  localparam int NW     = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int AW     = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_type,
  input  logic [NW-1:0]     req_src,
  input  logic [AW-1:0]     req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [2:0]        resp_type,
  output logic [NW-1:0]     resp_src,
  output logic [NW-1:0]     resp_dst,
  output logic [AW-1:0]     resp_addr,
  output logic [DATA_W-1:0] resp_data,
  output logic              resp_excl
);
  typedef struct packed {
    msg_e              typ;
    logic [NW-1:0]     src;
    logic [NW-1:0]     dst;
    logic              excl;
    logic [DATA_W-1:0] data;
  } omsg_t;

  function automatic logic [NODES-1:0] bit_of(input logic [NW-1:0] n);
    return {{(NODES-1){1'b0}}, 1'b1} << n;
  endfunction

  ctl_e              st_q, st_d;
  omsg_t             q0_q, q0_d, q1_q, q1_d;
  logic              q1v_q, q1v_d;
  logic [NODES-1:0]  inv_q, inv_d, ack_q, ack_d;
  logic [NW-1:0]     wr_q, wr_d;
  logic [AW-1:0]     addr_q, addr_d;

  logic [AW-1:0]     line_sel;
  line_e             rd_state;
  logic [NODES-1:0]  rd_vec, req_bit, others;
  logic [DATA_W-1:0] rd_data;
  logic              dir_we, dat_we;
  line_e             dir_wstate;
  logic [NODES-1:0]  dir_wvec;
  logic [NW-1:0]     own_idx, inv_idx;
  msg_e              rtype;

  assign rtype    = msg_e'(req_type);
  assign line_sel = (st_q == ST_IDLE) ? req_addr : addr_q;
  assign req_bit  = bit_of(req_src);
  assign others   = rd_vec & ~req_bit;

  dir_store #(.NODES(NODES), .LINES(LINES), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_n), .line_sel(line_sel),
    .rd_state(rd_state), .rd_vec(rd_vec), .rd_data(rd_data),
    .dir_we(dir_we), .dir_wstate(dir_wstate), .dir_wvec(dir_wvec),
    .dat_we(dat_we), .dat_wdata(req_data)
  );

  dir_lowbit #(.W(NODES), .IW(NW)) owner_pick_i (.vec(rd_vec), .idx(own_idx));
  dir_lowbit #(.W(NODES), .IW(NW)) inv_pick_i   (.vec(inv_q),  .idx(inv_idx));

  always_comb begin
    st_d = st_q; q0_d = q0_q; q1_d = q1_q; q1v_d = q1v_q;
    inv_d = inv_q; ack_d = ack_q; wr_d = wr_q; addr_d = addr_q;
    dir_we = 1'b0; dir_wstate = rd_state; dir_wvec = rd_vec; dat_we = 1'b0;
    req_ready = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          addr_d = req_addr;
          q1v_d  = 1'b0;
          q0_d   = '{typ: MSG_DATA_REPLY, src: NW'(HOME_ID), dst: req_src, excl: 1'b0, data: rd_data};
          case (rtype)
            MSG_READ: begin
              st_d = ST_OUT;
              unique case (rd_state)
                LN_UNUSED: begin
                  dir_we = 1'b1; dir_wstate = LN_EXCL_CLEAN; dir_wvec = req_bit;
                  q0_d.excl = 1'b1;
                end
                LN_SHARED: begin
                  dir_we = 1'b1; dir_wvec = rd_vec | req_bit;
                end
                LN_EXCL_CLEAN: begin
                  dir_we = 1'b1; dir_wstate = LN_SHARED; dir_wvec = rd_vec | req_bit;
                  q1_d  = q0_d;
                  q1v_d = 1'b1;
                  q0_d  = '{typ: MSG_SHARE, src: NW'(HOME_ID), dst: own_idx, excl: 1'b0, data: '0};
                end
                LN_EXCL_DIRTY: begin
                  q0_d = '{typ: MSG_FORWARD, src: req_src, dst: own_idx, excl: 1'b0, data: '0};
                end
              endcase
            end
            MSG_WRITE: begin
              if (others == '0) begin
                dir_we = 1'b1; dir_wstate = LN_EXCL_DIRTY; dir_wvec = req_bit;
                q0_d.excl = 1'b1;
                st_d = ST_OUT;
              end else begin
                inv_d = others;
                ack_d = others;
                wr_d  = req_src;
                st_d  = ST_INV;
              end
            end
            MSG_WRITEBACK: begin
              dat_we = 1'b1;
              if ((rd_state == LN_EXCL_CLEAN || rd_state == LN_EXCL_DIRTY) && rd_vec == req_bit) begin
                dir_we = 1'b1; dir_wstate = LN_UNUSED; dir_wvec = '0;
              end
            end
            default: ;
          endcase
        end
      end
      ST_OUT: begin
        if (resp_ready) begin
          if (q1v_q) begin
            q0_d  = q1_q;
            q1v_d = 1'b0;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      ST_INV, ST_ACK: begin
        req_ready = (rtype == MSG_INV_ACK);
        if (req_valid && req_ready) ack_d = ack_q & ~req_bit;
        if (st_q == ST_INV) begin
          if (resp_ready) begin
            inv_d = inv_q & ~bit_of(inv_idx);
            if (inv_d == '0) st_d = ST_ACK;
          end
        end else if (ack_q == '0) begin
          dir_we = 1'b1; dir_wstate = LN_EXCL_DIRTY; dir_wvec = bit_of(wr_q);
          q0_d  = '{typ: MSG_DATA_REPLY, src: NW'(HOME_ID), dst: wr_q, excl: 1'b1, data: rd_data};
          q1v_d = 1'b0;
          st_d  = ST_OUT;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      q0_q   <= '0;
      q1_q   <= '0;
      q1v_q  <= 1'b0;
      inv_q  <= '0;
      ack_q  <= '0;
      wr_q   <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      q0_q   <= q0_d;
      q1_q   <= q1_d;
      q1v_q  <= q1v_d;
      inv_q  <= inv_d;
      ack_q  <= ack_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
    end
  end

  always_comb begin
    resp_valid = (st_q == ST_OUT) || (st_q == ST_INV);
    resp_addr  = addr_q;
    if (st_q == ST_INV) begin
      resp_type = MSG_INVALIDATE;
      resp_src  = NW'(HOME_ID);
      resp_dst  = inv_idx;
      resp_data = '0;
      resp_excl = 1'b0;
    end else begin
      resp_type = q0_q.typ;
      resp_src  = q0_q.src;
      resp_dst  = q0_q.dst;
      resp_data = q0_q.data;
      resp_excl = q0_q.excl;
    end
  end

  // R10
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_type) && $stable(resp_dst)
                                     && $stable(resp_src) && $stable(resp_data) && $stable(resp_excl)));

  // R6
  inv_skips_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_type == MSG_INVALIDATE) |-> (resp_dst != wr_q));

  // R8
  pending_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACK) |-> !resp_valid);
endmodule

// File: tb/dir_home_ctrl_tb_top.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb_top;
  import dir_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_type = '0;
  logic [1:0]  req_src = '0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_data = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic [2:0]  resp_type;
  logic [1:0]  resp_src, resp_dst;
  logic [3:0]  resp_addr;
  logic [31:0] resp_data;
  logic        resp_excl;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dir_home_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_type(resp_type),
    .resp_src(resp_src), .resp_dst(resp_dst), .resp_addr(resp_addr),
    .resp_data(resp_data), .resp_excl(resp_excl)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive a request after the falling edge; return at the falling edge after it is taken
  task automatic send_req(input string tag, input msg_e t, input int src, input int addr, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_src = 2'(src); req_addr = 4'(addr); req_data = d;
    #1;
    check({tag, " req_ready"}, 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // compare the message present now, then let it be consumed
  task automatic expect_msg(input string tag, input msg_e t, input int dst, input int src,
                            input logic ex, input logic [31:0] d, input int addr);
    check(tag, {1'b1, resp_type, resp_dst, resp_src, resp_excl, resp_addr, resp_data},
               {1'b1, 3'(t), 2'(dst), 2'(src), ex, 4'(addr), d});
    check({tag, " valid"}, 64'(resp_valid), 64'd1);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_idle(input string tag);
    check(tag, 64'(resp_valid), 64'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset resp_valid", 64'(resp_valid), 64'd0);
    check("R1 reset req_ready", 64'(req_ready), 64'd1);
  endtask

  task automatic t_read_unused();
    send_req("R2", MSG_READ, 1, 3, '0);
    expect_msg("R2 exclusive grant", MSG_DATA_REPLY, 1, 0, 1'b1, 32'h0, 3);
    expect_idle("R2 single reply");
  endtask

  task automatic t_read_excl_clean();
    send_req("R3", MSG_READ, 2, 3, '0);
    expect_msg("R3 share to owner", MSG_SHARE, 1, 0, 1'b0, 32'h0, 3);
    expect_msg("R3 shared reply", MSG_DATA_REPLY, 2, 0, 1'b0, 32'h0, 3);
    expect_idle("R3 done");
  endtask

  task automatic t_read_shared();
    send_req("R4", MSG_READ, 3, 3, '0);
    expect_msg("R4 shared reply", MSG_DATA_REPLY, 3, 0, 1'b0, 32'h0, 3);
    expect_idle("R4 done");
  endtask

  task automatic t_write_with_sharers();
    send_req("R6", MSG_WRITE, 2, 3, '0);
    resp_ready = 1'b0;
    check("R6 first inv type", 64'(resp_type), 64'(MSG_INVALIDATE));
    @(posedge clk);
    @(negedge clk);
    resp_ready = 1'b1;
    expect_msg("R10 held inv to node1", MSG_INVALIDATE, 1, 0, 1'b0, 32'h0, 3);
    expect_msg("R6 inv to node3", MSG_INVALIDATE, 3, 0, 1'b0, 32'h0, 3);
    expect_idle("R6 no inv to writer");
    req_valid = 1'b1; req_type = MSG_READ; req_src = 2'd0; req_addr = 4'd5;
    #1;
    check("R8 read stalled", 64'(req_ready), 64'd0);
    @(posedge clk);
    @(negedge clk);
    check("R8 still stalled", 64'(req_ready), 64'd0);
    expect_idle("R8 silent while pending");
    req_valid = 1'b0;
    send_req("R7 ack1", MSG_INV_ACK, 1, 3, '0);
    expect_idle("R7 no reply after one ack");
    @(posedge clk);
    @(negedge clk);
    expect_idle("R7 still waiting");
    send_req("R7 ack3", MSG_INV_ACK, 3, 3, '0);
    expect_idle("R7 gap cycle");
    @(posedge clk);
    @(negedge clk);
    expect_msg("R7 writer reply", MSG_DATA_REPLY, 2, 0, 1'b1, 32'h0, 3);
    expect_idle("R7 done");
  endtask

  task automatic t_read_dirty();
    send_req("R5", MSG_READ, 1, 3, '0);
    expect_msg("R5 forward to owner", MSG_FORWARD, 2, 1, 1'b0, 32'h0, 3);
    expect_idle("R5 no data reply");
  endtask

  task automatic t_writeback_owner();
    send_req("R9 wb owner", MSG_WRITEBACK, 2, 3, 32'hCAFE);
    expect_idle("R9 writeback silent");
    send_req("R9", MSG_READ, 3, 3, '0);
    expect_msg("R9 line unused again", MSG_DATA_REPLY, 3, 0, 1'b1, 32'hCAFE, 3);
  endtask

  task automatic t_write_alone();
    send_req("R11", MSG_WRITE, 3, 3, '0);
    expect_msg("R11 immediate reply", MSG_DATA_REPLY, 3, 0, 1'b1, 32'hCAFE, 3);
    expect_idle("R11 done");
  endtask

  task automatic t_writeback_other();
    send_req("R9 wb non-owner", MSG_WRITEBACK, 1, 3, 32'h1234);
    expect_idle("R9 writeback silent 2");
    send_req("R9", MSG_READ, 0, 3, '0);
    expect_msg("R9 state unchanged", MSG_FORWARD, 3, 0, 1'b0, 32'h0, 3);
    send_req("R9 wb owner2", MSG_WRITEBACK, 3, 3, 32'h55);
    send_req("R9", MSG_READ, 1, 3, '0);
    expect_msg("R9 data stored", MSG_DATA_REPLY, 1, 0, 1'b1, 32'h55, 3);
  endtask

  task automatic t_other_line();
    send_req("R2 line", MSG_READ, 2, 9, '0);
    expect_msg("R2 other line unused", MSG_DATA_REPLY, 2, 0, 1'b1, 32'h0, 9);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_read_unused();
    t_read_excl_clean();
    t_read_shared();
    t_write_with_sharers();
    t_read_dirty();
    t_writeback_owner();
    t_write_alone();
    t_writeback_other();
    t_other_line();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      applied++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule